// File: doc/BRIEF.md
# Serial-Address Program Memory Programming Port

This block is the device-side controller that a programming station uses to load and read back a one-time-programmable program store. The port has no address pins. An internal address counter is zeroed by a mode code and then advanced by pulses on a separate address clock. Four mode pins choose among clearing the address, writing a word, reading a word back, and holding the array inhibited. A single enable input stands in for the high-voltage conditions that put the device into programming mode. While that input is low the port does nothing.

Every pin is brought into the block clock domain through a synchronizer before it is decoded. A word is committed to the array on the falling edge of mode bit 0 when that edge enters write mode. In verify mode the word at the current address is driven onto the data bus. The top words of the address space are a reserved test area. Writes to them are dropped and reads from them return zero. The array itself sits outside the block, behind a simple synchronous write port and a combinational read port.

Top module: `otp_prog_port`

## Requirements
- R1: After reset the address is 0, the data bus is not driven (busOe low), and no write strobe is issued.
- R2: With the mode pins written as {MD3,MD2,MD1,MD0}, the codes decode as follows: 4'b0101 is clear, 4'b1110 is write, 4'b1100 is verify, and 4'b11?1 is inhibit, where MD1 is don't-care. Any other code is idle. While progEnable is low every code is treated as idle.
- R3: The address returns to 0 only after the clear code has been held for CLEAR_HOLD consecutive clock cycles (default 16). A shorter hold leaves the address unchanged.
- R4: In any enabled mode other than clear, every four addrClk pulses advance the address by exactly one. The increment takes effect on the falling edge of the third pulse, so the address is unchanged while the third pulse is high and after the fourth pulse.
- R5: In verify mode busOe is high and busOut carries the array word at the current address.
- R6: In every mode other than verify, busOe is low. This includes the moment MD0 rises out of verify.
- R7: A falling MD0 that enters write mode issues exactly one memWrEn pulse. That pulse carries the busIn value and the current address.
- R8: Addresses at or above PROG_WORDS (2026, that is 0x7EA to 0x7FF) are reserved. A write there issues no memWrEn pulse, and a verify there drives busOut to 8'h00 whatever the array holds.
- R9: The count of addrClk pulses restarts from zero whenever the clear code is seen, however briefly, and whenever progEnable is low. A partial group of pulses is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progEnable | input | 1 | Programming-mode entry (stands in for the supply conditions) |
| modePins | input | 4 | Mode pins, bit 0 = MD0 through bit 3 = MD3 |
| addrClk | input | 1 | Address advance clock pin |
| busIn | input | 8 | Data bus, pad-to-core direction |
| busOut | output | 8 | Data bus, core-to-pad direction |
| busOe | output | 1 | Data bus output enable |
| memAddr | output | 11 | Array address |
| memWrEn | output | 1 | Array write strobe, one cycle |
| memWrData | output | 8 | Array write data |
| memRdData | input | 8 | Array read data at memAddr |

## Verification
The assertions check four properties on every cycle: each increment strobe moves the address by exactly one, a completed clear leaves the address at zero, write strobes never come on two cycles in a row, and the pulse counter sits at zero whenever the enable is low. They also check that the bus is never driven in a cycle that commits a write. Other behaviours can only be shown by the directed scenarios: that the increment lands on the third falling edge and not on another, that a brief clear discards a partial pulse group without moving the address, and that the reserved area drops writes and reads back zero. The scenarios also show the written data coming back through verify.

// File: rtl/otp_port_pkg.sv
package otp_port_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_CLEAR,
    MODE_WRITE,
    MODE_VERIFY,
    MODE_INHIBIT
  } portMode_t;

  typedef struct packed {
    logic clrAddr;
    logic incAddr;
    logic commitWr;
    logic driveBus;
  } progStrobes_t;

  // modePins bit order: [3]=MD3 .. [0]=MD0
  function automatic portMode_t decodeMode(input logic en, input logic [3:0] md);
    portMode_t m;
    if (!en) m = MODE_IDLE;
    else begin
      casez (md)
        4'b0101: m = MODE_CLEAR;
        4'b1110: m = MODE_WRITE;
        4'b1100: m = MODE_VERIFY;
        4'b11?1: m = MODE_INHIBIT;
        default: m = MODE_IDLE;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/otp_port_ctrl.sv
module otp_port_ctrl
  import otp_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CLEAR_HOLD  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progEnable,
  input  logic [3:0]        modePins,
  input  logic              addrClk,
  input  logic [DATA_W-1:0] busIn,
  output progStrobes_t      strobes,
  output logic [DATA_W-1:0] wrData
);

  localparam int SW    = DATA_W + 6;
  localparam int HOLD_W = $clog2(CLEAR_HOLD + 1);
  localparam int LAST  = SYNC_STAGES - 1;

  logic [SW-1:0] syncQ [SYNC_STAGES];
  logic [SW-1:0] rawIn;
  assign rawIn = {progEnable, addrClk, modePins, busIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
    end else begin
      syncQ[0] <= rawIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  logic       enS;
  logic       clkS;
  logic [3:0] mdS;
  assign enS    = syncQ[LAST][SW-1];
  assign clkS   = syncQ[LAST][SW-2];
  assign mdS    = syncQ[LAST][SW-3 -: 4];
  assign wrData = syncQ[LAST][DATA_W-1:0];

  portMode_t mode;
  assign mode = decodeMode(enS, mdS);

  logic prevClk;
  logic prevMd0;
  logic [1:0] pulseCnt;
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      prevMd0 <= 1'b0;
    end else begin
      prevClk <= clkS;
      prevMd0 <= mdS[0];
    end
  end

  logic clkRise;
  logic clkFall;
  assign clkRise = clkS && !prevClk;
  assign clkFall = !clkS && prevClk;

  // R9: pulse group restarts in clear mode or while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (!enS || mode == MODE_CLEAR) pulseCnt <= '0;
    else if (clkRise) pulseCnt <= pulseCnt + 2'd1;
  end

  // R3: clear must persist for CLEAR_HOLD consecutive cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (mode != MODE_CLEAR) holdCnt <= '0;
    else if (holdCnt != HOLD_W'(CLEAR_HOLD)) holdCnt <= holdCnt + 1'b1;
  end

  always_comb begin
    strobes.clrAddr  = (mode == MODE_CLEAR) && (holdCnt == HOLD_W'(CLEAR_HOLD - 1));
    // R4: third pulse high has ended
    strobes.incAddr  = clkFall && (pulseCnt == 2'd3) && enS && (mode != MODE_CLEAR);
    // R7: MD0 falling into write mode
    strobes.commitWr = (mode == MODE_WRITE) && prevMd0;
    strobes.driveBus = (mode == MODE_VERIFY);
  end

  a_r9_disabled_count_zero: assert property (@(posedge clk) disable iff (!rstN)
    !enS |=> pulseCnt == 2'd0);

  a_r6_no_drive_on_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.driveBus |-> !strobes.commitWr);

endmodule

// File: rtl/otp_port_datapath.sv
module otp_port_datapath
  import otp_port_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 11,
  parameter int PROG_WORDS = 2026
) (
  input  logic              clk,
  input  logic              rstN,
  input  progStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);

  localparam logic [ADDR_W-1:0] FIRST_RESERVED = ADDR_W'(PROG_WORDS);

  logic [ADDR_W-1:0] addr;
  logic inRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addr <= '0;
    else if (strobes.clrAddr) addr <= '0;
    else if (strobes.incAddr) addr <= addr + 1'b1;
  end

  // R8: reserved test area is masked at the port
  assign inRange   = addr < FIRST_RESERVED;
  assign memAddr   = addr;
  assign memWrEn   = strobes.commitWr && inRange;
  assign memWrData = wrData;
  assign busOe     = strobes.driveBus;
  assign busOut    = (strobes.driveBus && inRange) ? memRdData : '0;

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incAddr && !strobes.clrAddr |=> addr == ADDR_W'($past(addr) + 1'b1));

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrAddr |=> addr == '0);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
  import otp_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 11,
  parameter int PROG_WORDS  = 2026,
  parameter int SYNC_STAGES = 2,
  parameter int CLEAR_HOLD  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progEnable,
  input  logic [3:0]        modePins,
  input  logic              addrClk,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);

  progStrobes_t      strobes;
  logic [DATA_W-1:0] wrData;

  otp_port_ctrl #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .CLEAR_HOLD(CLEAR_HOLD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .progEnable(progEnable), .modePins(modePins),
    .addrClk(addrClk), .busIn(busIn), .strobes(strobes), .wrData(wrData)
  );

  otp_port_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PROG_WORDS(PROG_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .memRdData(memRdData), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .busOut(busOut), .busOe(busOe)
  );

endmodule

// File: tb/otp_prog_port_tb.sv
module otp_prog_port_tb;

  localparam logic [3:0] C_CLR = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b1110;
  localparam logic [3:0] C_VF  = 4'b1100;
  localparam logic [3:0] C_INH = 4'b1111;
  localparam logic [3:0] C_INB = 4'b1101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progEnable = 1'b0;
  logic [3:0] modePins = 4'b0000;
  logic addrClk = 1'b0;
  logic [7:0] busIn = 8'h00;
  logic [7:0] busOut;
  logic busOe;
  logic [10:0] memAddr;
  logic memWrEn;
  logic [7:0] memWrData;
  logic [7:0] memRdData;

  int checks = 0;
  int fails = 0;
  int wrCount = 0;
  bit done = 1'b0;

  logic [7:0] mem [0:2047];

  always #4 clk = ~clk;

  otp_prog_port u_dut (
    .clk(clk), .rstN(rstN), .progEnable(progEnable), .modePins(modePins),
    .addrClk(addrClk), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdData(memRdData)
  );

  assign memRdData = mem[memAddr];

  always @(posedge clk) begin
    if (memWrEn) begin
      mem[memAddr] <= memWrData;
      wrCount <= wrCount + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(input logic [3:0] code);
    modePins = code;
    settle(6);
  endtask

  task automatic pulse();
    addrClk = 1'b1; settle(3);
    addrClk = 1'b0; settle(3);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < 4 * n; i++) pulse();
  endtask

  task automatic writeWord(input logic [7:0] d);
    busIn = d;
    setMode(C_INH);
    setMode(C_WR);
    setMode(C_INH);
  endtask

  task automatic verifyWord(input string req, input logic [7:0] exp);
    setMode(C_VF);
    chk({req, " verify drives bus"}, 32'(busOe), 32'd1);
    chk({req, " verify data"}, 32'(busOut), 32'(exp));
    setMode(C_INB);
    chk("R6 bus floats after MD0 rise", 32'(busOe), 32'd0);
  endtask

  task automatic fullClear();
    setMode(C_CLR);
    settle(20);
    setMode(C_INH);
  endtask

  task automatic testReset();
    chk("R1 address after reset", 32'(memAddr), 32'd0);
    chk("R1 bus idle after reset", 32'(busOe), 32'd0);
    chk("R1 no write after reset", 32'(wrCount), 32'd0);
  endtask

  task automatic testClearHold();
    progEnable = 1'b1;
    setMode(C_INH);
    step(3);
    chk("R4 three groups of pulses", 32'(memAddr), 32'd3);
    modePins = C_CLR; settle(5);
    setMode(C_INH);
    chk("R3 short clear keeps address", 32'(memAddr), 32'd3);
    fullClear();
    chk("R3 held clear zeroes address", 32'(memAddr), 32'd0);
  endtask

  task automatic testThirdEdge();
    pulse(); pulse();
    addrClk = 1'b1; settle(4);
    chk("R4 no step while third pulse high", 32'(memAddr), 32'd0);
    addrClk = 1'b0; settle(4);
    chk("R4 step on third falling edge", 32'(memAddr), 32'd1);
    pulse();
    chk("R4 fourth pulse adds nothing", 32'(memAddr), 32'd1);
  endtask

  task automatic testWriteVerify();
    int base;
    base = wrCount;
    writeWord(8'hA5);
    chk("R7 one strobe per MD0 fall", 32'(wrCount), 32'(base + 1));
    chk("R7 word stored at address 1", 32'(mem[1]), 32'h0A5);
    verifyWord("R5", 8'hA5);
    step(1);
    writeWord(8'h5A);
    verifyWord("R5 second pattern", 8'h5A);
    chk("R7 verify causes no write", 32'(wrCount), 32'(base + 2));
    fullClear();
    step(1);
    verifyWord("R5 readback after clear", 8'hA5);
  endtask

  task automatic testPulseRestart();
    // address 1 here
    pulse(); pulse();
    progEnable = 1'b0; settle(6);
    progEnable = 1'b1; settle(6);
    pulse(); pulse();
    chk("R9 disable discards partial group", 32'(memAddr), 32'd1);
    pulse(); pulse();
    chk("R9 group restarts after enable", 32'(memAddr), 32'd2);
    pulse(); pulse();
    modePins = C_CLR; settle(5);
    setMode(C_INH);
    pulse(); pulse();
    chk("R9 brief clear discards partial group", 32'(memAddr), 32'd2);
    pulse(); pulse();
    chk("R9 group restarts after clear", 32'(memAddr), 32'd3);
  endtask

  task automatic testDecode();
    int base;
    base = wrCount;
    setMode(4'b0000);
    chk("R2 idle code does not drive", 32'(busOe), 32'd0);
    setMode(C_INH);
    progEnable = 1'b0; settle(6);
    setMode(C_VF);
    chk("R2 disabled verify does not drive", 32'(busOe), 32'd0);
    setMode(C_INH);
    busIn = 8'h11;
    setMode(C_WR);
    setMode(C_INH);
    chk("R2 disabled write ignored", 32'(wrCount), 32'(base));
    progEnable = 1'b1; settle(6);
    setMode(C_VF);
    setMode(C_WR);
    setMode(C_INH);
    chk("R2 entering write from verify makes no strobe", 32'(wrCount), 32'(base));
  endtask

  task automatic testReserved();
    int base;
    fullClear();
    step(2025);
    chk("R8 last program address reached", 32'(memAddr), 32'h7E9);
    base = wrCount;
    writeWord(8'h3C);
    chk("R8 last program address writable", 32'(wrCount), 32'(base + 1));
    verifyWord("R8 last program address", 8'h3C);
    step(1);
    chk("R8 first reserved address", 32'(memAddr), 32'h7EA);
    writeWord(8'h77);
    chk("R8 reserved write dropped", 32'(wrCount), 32'(base + 1));
    verifyWord("R8 reserved reads zero", 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
    settle(3);
    rstN = 1'b1;
    settle(3);
    testReset();
    testClearHold();
    testThirdEdge();
    testWriteVerify();
    testPulseRestart();
    testDecode();
    testReserved();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule